// File: doc/BRIEF.md
# Node Input Buffer Manager

This block sits at the network input of one node in a distributed-memory machine. Every arriving message carries a flag that marks it as a request or a response, plus the identity of the sending node. Requests and responses go into two separate queues, and each queue has its own enqueue and dequeue side. The local protocol engine drains the two queues through two independent dequeue ports.

Request space is reserved per sending node with credits. Each of the P−1 other nodes may have at most K requests outstanding here. A request counts as outstanding from the moment it is accepted until the engine returns its credit on the credit-return port, which it does once the matching reply has gone out. If a request arrives from a node with no credit left, the block does not stall the link. It drops the request and raises a negative acknowledgement (NACK) naming that node, so the sender can retry. Responses are never refused.

Together these rules mean the node keeps draining the network even while its own outgoing path is blocked. This is what avoids fetch deadlock. The request queue holds K·(P−1) entries and the response queue holds K entries.

Top module: `nibm_top`

## Requirements
- R1: After reset, `rq_valid`, `rs_valid` and `nack_valid` are low, and every source starts with K credits.
- R2: A request (`in_is_resp`=0) from a source with nonzero credit is queued. It appears on the request dequeue port in arrival order, with its source and data, and leaves when `rq_pop` is high.
- R3: A response (`in_is_resp`=1) is always queued, never NACKed and never dropped. Responses appear on the response dequeue port in arrival order.
- R4: A request whose source has zero credit is not queued. In the next cycle `nack_valid` is high for one cycle, with `nack_src` equal to that source.
- R5: A pulse on `rel_valid` adds one credit to source `rel_src`, saturating at K, so a later request from that source is accepted.
- R6: No source ever has more than K requests outstanding (accepted and not yet released), so the request queue never holds more than K·(P−1) entries.
- R7: When a request and a credit release arrive in the same cycle, the request is judged on the credit count from before the release. Both take effect, whether the two name the same source or different sources.
- R8: An enqueue and a dequeue on the same queue in the same cycle both take effect, and no entry is lost or duplicated.
- R9: A full request queue that is not being drained does not stop responses from being accepted and delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming message present |
| in_is_resp | input | 1 | 1 = response, 0 = request |
| in_src | input | SRC_W | Sending node index, 0 to P−2 |
| in_data | input | DATA_W | Message word |
| rel_valid | input | 1 | Credit return strobe |
| rel_src | input | SRC_W | Source whose credit is returned |
| nack_valid | output | 1 | A request was refused last cycle |
| nack_src | output | SRC_W | Source of the refused request |
| rq_valid | output | 1 | Request queue not empty |
| rq_src | output | SRC_W | Source of the head request |
| rq_data | output | DATA_W | Data of the head request |
| rq_pop | input | 1 | Dequeue the head request |
| rs_valid | output | 1 | Response queue not empty |
| rs_src | output | SRC_W | Source of the head response |
| rs_data | output | DATA_W | Data of the head response |
| rs_pop | input | 1 | Dequeue the head response |

## Verification
Two functions can fall in the same cycle: a credit release, and the credit decision for an incoming request. A release also has a second partner, the enqueue and dequeue of one queue. The bench provokes the first case by driving a release together with a request on the same clock edge, in two forms: with the request's source at zero credit and releasing that same source, and with the request and the release naming different sources. It judges the result by whether a NACK appears one cycle later, and by whether the next request from the released source is accepted. The second case is provoked with back-to-back bursts while the scoreboard monitor pops every cycle. The scoreboard then shows that every message comes out exactly once, in order.

// File: rtl/nibm_pkg.sv
package nibm_pkg;
  typedef enum logic {
    KIND_REQ  = 1'b0,
    KIND_RESP = 1'b1
  } msg_kind_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/nibm_fifo.sv
module nibm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = nibm_pkg::idx_width(DEPTH),
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          valid,
  output logic [NW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [NW-1:0] n;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop && (n != '0);
  assign do_push = push && ((n != NW'(DEPTH)) || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
      n  <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   n <= n + 1'b1;
        2'b01:   n <= n - 1'b1;
        default: n <= n;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign valid = (n != '0);
  assign count = n;
endmodule

// File: rtl/nibm_credit.sv
module nibm_credit #(
  parameter int SRCS  = 3,
  parameter int K     = 2,
  parameter int SRC_W = 2,
  localparam int CW   = $clog2(K + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_v,
  input  logic [SRC_W-1:0]   take_src,
  input  logic               give_v,
  input  logic [SRC_W-1:0]   give_src,
  output logic               ok,
  output logic [SRCS*CW-1:0] cnt_flat
);
  logic [SRCS-1:0] ok_vec;

  for (genvar i = 0; i < SRCS; i++) begin : g_src
    logic [CW-1:0] c;
    logic hit, nz, dec, inc;
    assign hit = (take_src == SRC_W'(i));
    assign nz  = (c != '0);
    assign dec = take_v && hit && nz;
    assign inc = give_v && (give_src == SRC_W'(i)) && (c != CW'(K));
    always_ff @(posedge clk) begin
      if (rst) c <= CW'(K);
      else     c <= c - CW'(dec) + CW'(inc);
    end
    assign ok_vec[i] = hit && nz;
    assign cnt_flat[i*CW +: CW] = c;
  end

  assign ok = |ok_vec;
endmodule

// File: rtl/nibm_top.sv
module nibm_top #(
  parameter int NODES    = 4,
  parameter int K        = 2,
  parameter int DATA_W   = 16,
  localparam int SRCS    = NODES - 1,
  localparam int SRC_W   = nibm_pkg::idx_width(SRCS),
  localparam int RQ_DEP  = SRCS * K,
  localparam int RQ_CW   = $clog2(RQ_DEP + 1),
  localparam int RS_CW   = $clog2(K + 1),
  localparam int CW      = $clog2(K + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_is_resp,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rel_valid,
  input  logic [SRC_W-1:0]  rel_src,
  output logic              nack_valid,
  output logic [SRC_W-1:0]  nack_src,
  output logic              rq_valid,
  output logic [SRC_W-1:0]  rq_src,
  output logic [DATA_W-1:0] rq_data,
  input  logic              rq_pop,
  output logic              rs_valid,
  output logic [SRC_W-1:0]  rs_src,
  output logic [DATA_W-1:0] rs_data,
  input  logic              rs_pop
);
  import nibm_pkg::*;

  msg_kind_e                  kind;
  logic                       is_req, is_resp, cred_ok, rq_push;
  logic [SRCS*CW-1:0]         cred_cnt;
  logic [RQ_CW-1:0]           rq_cnt;
  logic [RS_CW-1:0]           rs_cnt;
  logic [SRC_W+DATA_W-1:0]    rq_word, rs_word;

  assign kind    = msg_kind_e'(in_is_resp);
  assign is_req  = in_valid && (kind == KIND_REQ);
  assign is_resp = in_valid && (kind == KIND_RESP);
  assign rq_push = is_req && cred_ok;

  nibm_credit #(.SRCS(SRCS), .K(K), .SRC_W(SRC_W)) u_cred (
    .clk(clk), .rst(rst),
    .take_v(is_req), .take_src(in_src),
    .give_v(rel_valid), .give_src(rel_src),
    .ok(cred_ok), .cnt_flat(cred_cnt)
  );

  nibm_fifo #(.W(SRC_W + DATA_W), .DEPTH(RQ_DEP)) u_rq (
    .clk(clk), .rst(rst),
    .push(rq_push), .din({in_src, in_data}),
    .pop(rq_pop), .dout(rq_word), .valid(rq_valid), .count(rq_cnt)
  );

  nibm_fifo #(.W(SRC_W + DATA_W), .DEPTH(K)) u_rs (
    .clk(clk), .rst(rst),
    .push(is_resp), .din({in_src, in_data}),
    .pop(rs_pop), .dout(rs_word), .valid(rs_valid), .count(rs_cnt)
  );

  assign {rq_src, rq_data} = rq_word;
  assign {rs_src, rs_data} = rs_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      nack_valid <= 1'b0;
      nack_src   <= '0;
    end else begin
      nack_valid <= is_req && !cred_ok;
      nack_src   <= in_src;
    end
  end
endmodule

// File: rtl/nibm_chk.sv
module nibm_chk #(
  parameter int SRCS  = 3,
  parameter int K     = 2,
  parameter int SRC_W = 2,
  parameter int RQ_CW = 3,
  parameter int RS_CW = 2,
  parameter int CW    = 2,
  localparam int SW   = $clog2(SRCS * K + 1) + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_is_resp,
  input logic [SRC_W-1:0]   in_src,
  input logic               nack_valid,
  input logic [SRC_W-1:0]   nack_src,
  input logic               rq_valid,
  input logic               rs_valid,
  input logic               rs_pop,
  input logic [RQ_CW-1:0]   rq_cnt,
  input logic [RS_CW-1:0]   rs_cnt,
  input logic [SRCS*CW-1:0] cred_cnt
);
  logic [SW-1:0] cred_sum;

  always_comb begin
    cred_sum = '0;
    for (int i = 0; i < SRCS; i++) cred_sum = cred_sum + SW'(cred_cnt[i*CW +: CW]);
  end

  assert_reservation_R6: assert property (@(posedge clk) disable iff (rst)
    (SW'(rq_cnt) + cred_sum) <= SW'(SRCS * K));

  assert_nack_cause_R4: assert property (@(posedge clk) disable iff (rst)
    nack_valid |-> $past(in_valid && !in_is_resp));

  assert_nack_src_R4: assert property (@(posedge clk) disable iff (rst)
    nack_valid |-> (nack_src == $past(in_src)));

  assert_req_resolved_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_is_resp) |=> (nack_valid || rq_valid));

  assert_resp_taken_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_is_resp && !rs_pop) |=> rs_valid);

  assert_resp_bound_R3: assert property (@(posedge clk) disable iff (rst)
    rs_cnt <= RS_CW'(K));
endmodule

bind nibm_top nibm_chk #(
  .SRCS(SRCS), .K(K), .SRC_W(SRC_W), .RQ_CW(RQ_CW), .RS_CW(RS_CW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_resp(in_is_resp),
  .in_src(in_src), .nack_valid(nack_valid), .nack_src(nack_src),
  .rq_valid(rq_valid), .rs_valid(rs_valid), .rs_pop(rs_pop),
  .rq_cnt(rq_cnt), .rs_cnt(rs_cnt), .cred_cnt(cred_cnt)
);

// File: tb/sim_nibm_top.sv
module sim_nibm_top;
  localparam int NODES  = 4;
  localparam int K      = 2;
  localparam int DATA_W = 16;
  localparam int SRCS   = NODES - 1;
  localparam int SRC_W  = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_is_resp = 0, rel_valid = 0;
  logic [SRC_W-1:0] in_src = '0, rel_src = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic nack_valid, rq_valid, rs_valid, rq_pop, rs_pop;
  logic [SRC_W-1:0] nack_src, rq_src, rs_src;
  logic [DATA_W-1:0] rq_data, rs_data;

  always #2 clk = ~clk;

  nibm_top #(.NODES(NODES), .K(K), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_resp(in_is_resp),
    .in_src(in_src), .in_data(in_data), .rel_valid(rel_valid), .rel_src(rel_src),
    .nack_valid(nack_valid), .nack_src(nack_src),
    .rq_valid(rq_valid), .rq_src(rq_src), .rq_data(rq_data), .rq_pop(rq_pop),
    .rs_valid(rs_valid), .rs_src(rs_src), .rs_data(rs_data), .rs_pop(rs_pop)
  );

  int total = 0, bad = 0;
  int cred[SRCS];
  logic [SRC_W+DATA_W-1:0] exp_rq[$], exp_rs[$];
  bit drain_rq = 0, drain_rs = 0;
  bit pend_nack = 0;
  int pend_src = 0;
  int seqn = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    rq_pop = 0; rs_pop = 0;
    forever begin
      @(negedge clk);
      if (rst) begin rq_pop = 0; rs_pop = 0; end
      else begin
        if (drain_rq && rq_valid) begin
          if (exp_rq.size() == 0) chk(0, "R2 unexpected request", {rq_src, rq_data}, 0);
          else begin
            chk({rq_src, rq_data} == exp_rq[0], "R2 request order", {rq_src, rq_data}, exp_rq[0]);
            void'(exp_rq.pop_front());
          end
          rq_pop = 1;
        end else rq_pop = 0;
        if (drain_rs && rs_valid) begin
          if (exp_rs.size() == 0) chk(0, "R3 unexpected response", {rs_src, rs_data}, 0);
          else begin
            chk({rs_src, rs_data} == exp_rs[0], "R3 response order", {rs_src, rs_data}, exp_rs[0]);
            void'(exp_rs.pop_front());
          end
          rs_pop = 1;
        end else rs_pop = 0;
      end
    end
  end

  // driver: call at a falling edge, then tick()
  task automatic drive(input bit v, input bit resp, input int src, input bit rv, input int rsrc);
    logic [DATA_W-1:0] d;
    seqn++;
    d = DATA_W'(16'h5A00 + seqn);
    in_valid = v; in_is_resp = resp; in_src = SRC_W'(src); in_data = d;
    rel_valid = rv; rel_src = SRC_W'(rsrc);
    pend_nack = 0;
    if (v && !resp) begin
      if (cred[src] > 0) begin cred[src]--; exp_rq.push_back({SRC_W'(src), d}); end
      else begin pend_nack = 1; pend_src = src; end
    end
    if (v && resp) exp_rs.push_back({SRC_W'(src), d});
    if (rv && cred[rsrc] < K) cred[rsrc]++;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(nack_valid == pend_nack, "R4 nack flag", nack_valid, pend_nack);
    if (pend_nack) chk(nack_src == SRC_W'(pend_src), "R4 nack source", nack_src, pend_src);
    in_valid = 0; rel_valid = 0;
  endtask

  task automatic wait_drain(input string req);
    for (int i = 0; i < 60 && (exp_rq.size() != 0 || exp_rs.size() != 0); i++) @(negedge clk);
    @(negedge clk);
    chk(exp_rq.size() == 0 && exp_rs.size() == 0, req, exp_rq.size() + exp_rs.size(), 0);
  endtask

  task automatic release_all();
    for (int s = 0; s < SRCS; s++)
      while (cred[s] < K) begin drive(0, 0, 0, 1, s); tick(); end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int s = 0; s < SRCS; s++) cred[s] = K;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!rq_valid, "R1 rq_valid after reset", rq_valid, 0);
    chk(!rs_valid, "R1 rs_valid after reset", rs_valid, 0);
    chk(!nack_valid, "R1 nack after reset", nack_valid, 0);

    // R2 / R3 basic traffic, one per source
    drain_rq = 1; drain_rs = 1;
    for (int s = 0; s < SRCS; s++) begin drive(1, 0, s, 0, 0); tick(); end
    drive(1, 1, 2, 0, 0); tick();
    wait_drain("R2 basic requests drained");
    release_all();

    // R1 / R4 / R5: K accepted from source 0, then NACK, then release restores
    for (int i = 0; i < K; i++) begin drive(1, 0, 0, 0, 0); tick(); end
    drive(1, 0, 0, 0, 0); tick();          // R4 refused
    wait_drain("R4 refused request not queued");
    drive(0, 0, 0, 1, 0); tick();          // R5 one credit back
    drive(1, 0, 0, 0, 0); tick();          // R5 accepted again
    drive(1, 0, 0, 0, 0); tick();          // R4 refused again
    wait_drain("R5 request after release delivered");

    // R7: same-source release with zero credit -> still NACK, then accepted
    for (int i = 0; i < K; i++) begin drive(1, 0, 1, 0, 0); tick(); end
    wait_drain("R7 setup drained");
    drive(1, 0, 1, 1, 1); tick();          // R7 nack + credit returned
    drive(1, 0, 1, 0, 0); tick();          // R7 accepted by returned credit
    // R7: request from source 2 alongside release for source 0
    drive(1, 0, 2, 1, 0); tick();
    drive(1, 0, 0, 0, 0); tick();          // R7 source 0 uses released credit
    // R7: refused source 0 alongside release for source 2
    drive(1, 0, 0, 1, 2); tick();
    wait_drain("R7 combined cycles delivered");
    release_all();

    // R9 / R6: fill request queue without draining, responses still flow
    drain_rq = 0;
    for (int s = 0; s < SRCS; s++)
      for (int i = 0; i < K; i++) begin drive(1, 0, s, 0, 0); tick(); end
    for (int s = 0; s < SRCS; s++) begin drive(1, 0, s, 0, 0); tick(); end  // R6 all refused
    for (int i = 0; i < K; i++) begin drive(1, 1, i, 0, 0); tick(); end
    repeat (4) @(negedge clk);
    chk(exp_rs.size() == 0, "R9 responses delivered past full request queue", exp_rs.size(), 0);
    chk(rq_valid, "R9 request queue still held", rq_valid, 1);
    chk(exp_rq.size() == SRCS * K, "R6 queued requests equal reservation", exp_rq.size(), SRCS * K);
    drain_rq = 1;
    wait_drain("R6 full queue drained in order");
    release_all();

    // R8: back-to-back bursts with popping every cycle
    for (int i = 0; i < 6; i++) begin drive(1, 1, i % SRCS, 0, 0); tick(); end
    for (int i = 0; i < 6; i++) begin drive(1, 0, i % SRCS, 0, 0); tick(); end
    for (int i = 0; i < 6; i++) begin drive(1, i % 2, i % SRCS, 0, 0); tick(); end
    wait_drain("R8 bursts delivered exactly once");
    chk(!rq_valid && !rs_valid, "R8 queues empty after bursts", {rq_valid, rs_valid}, 0);
    finish_run();
  end
endmodule